// File: doc/BRIEF.md
# Candidate Trial Division Checker

This unit screens one sieve candidate at a time against a list of factor-base primes. A candidate is a pair (a, b), where a is a signed integer and b is positive. Each factor-base entry is a prime p together with a root s of the sieving polynomial modulo p. The candidate is divisible by p exactly when the linear form a + b·s is congruent to zero modulo p. The unit never builds the large polynomial value. For each entry it forms one wide product b·s, adds a, and reduces the sum modulo p with a restoring divider that retires one dividend bit per cycle.

A candidate is accepted on a valid/ready stream. A side-select bit travels with it and chooses the prime bound: rational side up to 2^30, algebraic side up to 2^27. Factor-base entries follow on a second valid/ready stream, and the last entry for the candidate carries a last flag. Entries whose prime exceeds the bound for the selected side are consumed but not tested. For every prime that divides the candidate, the unit emits one record on an output valid/ready stream. After the last entry it emits one end marker. This screening runs before any primality test or further factoring of the cofactor.

Top module: `trialdiv_top`

## Requirements
- R1: After reset, outValid is 0, candReady is 1 and entReady is 0.
- R2: An entry (p, s) that is tested yields a record with outPrime = p and outEnd = 0 exactly when (a + b·s) mod p equals 0.
- R3: A negative sum a + b·s is brought into the range 0..p-1 before the zero test, so the test is correct for any sign of a.
- R4: b and s are taken at their full 32-bit width, and the 64-bit product b·s is reduced exactly.
- R5: With candAlg = 0, primes up to and including 2^30 are tested. With candAlg = 1, primes up to and including 2^27 are tested. A prime above the selected bound is consumed and produces no record.
- R6: Records appear in the order their entries were accepted. After the entry flagged entLast has been handled, exactly one end marker follows, with outEnd = 1 and outPrime = 0.
- R7: While outValid is 1 and outReady is 0, outValid, outPrime and outEnd hold their values.
- R8: From candidate acceptance until its end marker is accepted, candReady is 0. entReady is 0 while a division is in progress or a record is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| candValid | input | 1 | Candidate offered |
| candReady | output | 1 | Unit can take a candidate |
| candA | input | 32 | Signed coordinate a |
| candB | input | 32 | Positive coordinate b |
| candAlg | input | 1 | 0 selects the rational bound, 1 selects the algebraic bound |
| entValid | input | 1 | Factor-base entry offered |
| entReady | output | 1 | Unit can take an entry |
| entPrime | input | 32 | Prime p |
| entRoot | input | 32 | Root s, with s < p |
| entLast | input | 1 | Entry is the last for this candidate |
| outValid | output | 1 | Record or end marker offered |
| outReady | input | 1 | Consumer takes the record |
| outPrime | output | 32 | Dividing prime, or 0 for the end marker |
| outEnd | output | 1 | Record is the end-of-candidate marker |

## Verification
The assertions assume that every prime is at least 2 and that each root is smaller than its prime. Under these conditions the divider remainder stays below p and the normalized residue lands in 0..p-1. The stimulus uses only such entries, some of which are composite moduli, and drives b no lower than 0. The hold check on the output assumes the consumer keeps outReady low for a whole cycle at a time. The bench holds outReady low over several cycles while it samples the record.

// File: rtl/trialdiv_pkg.sv
package trialdiv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_DIVIDE, ST_REPORT, ST_FINISH
  } ctrlState;

  typedef struct packed {
    logic loadCand;
    logic loadEntry;
    logic startDiv;
  } ctrlStrobes;
endpackage

// File: rtl/trialdiv_datapath.sv
module trialdiv_datapath
  import trialdiv_pkg::*;
#(
  parameter int A_W = 32,
  parameter int B_W = 32,
  parameter int S_W = 32,
  parameter int P_W = 32,
  parameter longint RAT_BOUND = 64'd1073741824,
  parameter longint ALG_BOUND = 64'd134217728
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes            strb,
  input  logic signed [A_W-1:0] candA,
  input  logic [B_W-1:0]        candB,
  input  logic                  candAlg,
  input  logic [P_W-1:0]        entPrime,
  input  logic [S_W-1:0]        entRoot,
  output logic [P_W-1:0]        pReg,
  output logic                  pInRange,
  output logic                  divBusy,
  output logic                  divDone,
  output logic                  isZero
);
  localparam int PROD_W = B_W + S_W;
  localparam int MAG_W  = PROD_W + 1;
  localparam int SUM_W  = PROD_W + 2;
  localparam int CNT_W  = $clog2(MAG_W + 1);

  logic signed [A_W-1:0] aReg;
  logic [B_W-1:0]        bReg;
  logic [S_W-1:0]        sReg;
  logic                  algReg;
  logic [MAG_W-1:0]      dvd;
  logic [P_W-1:0]        rem;
  logic [CNT_W-1:0]      cnt;
  logic                  negReg;

  logic [PROD_W-1:0]       prod;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] negSum;
  logic [MAG_W-1:0]        mag;
  logic [P_W:0]            remShift;
  logic [P_W:0]            remNext;
  logic [P_W-1:0]          resid;
  logic [P_W-1:0]          bound;

  // Wide product and signed sum of the linear form
  assign prod     = PROD_W'(bReg) * PROD_W'(sReg);
  assign sum      = $signed({2'b00, prod}) + SUM_W'(aReg);
  assign negSum   = -sum;
  assign mag      = sum[SUM_W-1] ? negSum[MAG_W-1:0] : sum[MAG_W-1:0];

  // One restoring step per cycle
  assign remShift = {rem, dvd[MAG_W-1]};
  assign remNext  = (remShift >= {1'b0, pReg}) ? remShift - {1'b0, pReg} : remShift;

  // Residue of a negative sum folded into 0..p-1
  assign resid    = (negReg && rem != '0) ? pReg - rem : rem;
  assign isZero   = (resid == '0);

  assign bound    = algReg ? P_W'(ALG_BOUND) : P_W'(RAT_BOUND);
  assign pInRange = (pReg <= bound);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg    <= '0;
      bReg    <= '0;
      sReg    <= '0;
      algReg  <= 1'b0;
      pReg    <= '0;
      dvd     <= '0;
      rem     <= '0;
      cnt     <= '0;
      negReg  <= 1'b0;
      divBusy <= 1'b0;
      divDone <= 1'b0;
    end else begin
      divDone <= 1'b0;
      if (strb.loadCand) begin
        aReg   <= candA;
        bReg   <= candB;
        algReg <= candAlg;
      end
      if (strb.loadEntry) begin
        pReg <= entPrime;
        sReg <= entRoot;
      end
      if (strb.startDiv) begin
        dvd     <= mag;
        negReg  <= sum[SUM_W-1];
        rem     <= '0;
        cnt     <= CNT_W'(MAG_W);
        divBusy <= 1'b1;
      end else if (divBusy) begin
        rem <= remNext[P_W-1:0];
        dvd <= {dvd[MAG_W-2:0], 1'b0};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          divBusy <= 1'b0;
          divDone <= 1'b1;
        end
      end
    end
  end

  // R2: the partial remainder never reaches the modulus
  a_r2_rem_below_p: assert property (@(posedge clk) disable iff (!rstN)
    divBusy |-> rem < pReg);
  // R2: a start strobe always engages the divider
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.startDiv |=> divBusy);
  // R3: the folded residue lies in 0..p-1
  a_r3_resid_in_range: assert property (@(posedge clk) disable iff (!rstN)
    divDone |-> resid < pReg);
endmodule

// File: rtl/trialdiv_ctrl.sv
module trialdiv_ctrl
  import trialdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       candValid,
  output logic       candReady,
  input  logic       entValid,
  output logic       entReady,
  input  logic       entLast,
  output logic       outValid,
  input  logic       outReady,
  output logic       outEnd,
  input  logic       pInRange,
  input  logic       divBusy,
  input  logic       divDone,
  input  logic       isZero,
  output ctrlStrobes strb
);
  ctrlState state, nextState;
  ctrlState afterEntry;
  logic     lastReg;

  assign afterEntry = lastReg ? ST_FINISH : ST_FETCH;
  assign candReady  = (state == ST_IDLE);
  assign entReady   = (state == ST_FETCH);
  assign outValid   = (state == ST_REPORT) || (state == ST_FINISH);
  assign outEnd     = (state == ST_FINISH);

  always_comb begin
    strb.loadCand  = (state == ST_IDLE) && candValid;
    strb.loadEntry = (state == ST_FETCH) && entValid;
    strb.startDiv  = (state == ST_CHECK) && pInRange;
    nextState = state;
    unique case (state)
      ST_IDLE:   if (candValid) nextState = ST_FETCH;
      ST_FETCH:  if (entValid) nextState = ST_CHECK;
      ST_CHECK:  nextState = pInRange ? ST_DIVIDE : afterEntry;
      ST_DIVIDE: if (divDone) nextState = isZero ? ST_REPORT : afterEntry;
      ST_REPORT: if (outReady) nextState = afterEntry;
      ST_FINISH: if (outReady) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lastReg <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.loadEntry) lastReg <= entLast;
    end
  end

  // R8: nothing is taken or offered while the divider runs
  a_r8_busy_quiet: assert property (@(posedge clk) disable iff (!rstN)
    divBusy |-> !entReady && !candReady && !outValid);
  // R6: an accepted end marker returns the unit to candidate intake
  a_r6_end_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outEnd && outReady |=> candReady);
endmodule

// File: rtl/trialdiv_top.sv
module trialdiv_top
  import trialdiv_pkg::*;
#(
  parameter int A_W = 32,
  parameter int B_W = 32,
  parameter int S_W = 32,
  parameter int P_W = 32,
  parameter longint RAT_BOUND = 64'd1073741824,
  parameter longint ALG_BOUND = 64'd134217728
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  candValid,
  output logic                  candReady,
  input  logic signed [A_W-1:0] candA,
  input  logic [B_W-1:0]        candB,
  input  logic                  candAlg,
  input  logic                  entValid,
  output logic                  entReady,
  input  logic [P_W-1:0]        entPrime,
  input  logic [S_W-1:0]        entRoot,
  input  logic                  entLast,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [P_W-1:0]        outPrime,
  output logic                  outEnd
);
  ctrlStrobes     strb;
  logic [P_W-1:0] pReg;
  logic           pInRange, divBusy, divDone, isZero;

  trialdiv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .candValid(candValid), .candReady(candReady),
    .entValid(entValid), .entReady(entReady), .entLast(entLast),
    .outValid(outValid), .outReady(outReady), .outEnd(outEnd),
    .pInRange(pInRange), .divBusy(divBusy), .divDone(divDone),
    .isZero(isZero), .strb(strb)
  );

  trialdiv_datapath #(
    .A_W(A_W), .B_W(B_W), .S_W(S_W), .P_W(P_W),
    .RAT_BOUND(RAT_BOUND), .ALG_BOUND(ALG_BOUND)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .candA(candA), .candB(candB), .candAlg(candAlg),
    .entPrime(entPrime), .entRoot(entRoot),
    .pReg(pReg), .pInRange(pInRange),
    .divBusy(divBusy), .divDone(divDone), .isZero(isZero)
  );

  assign outPrime = outEnd ? '0 : pReg;

  // R7: a stalled record keeps its content
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outPrime) && $stable(outEnd));
endmodule

// File: tb/trialdiv_top_test.sv
module trialdiv_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic candValid = 1'b0, candAlg = 1'b0;
  logic signed [31:0] candA = '0;
  logic [31:0] candB = '0;
  logic entValid = 1'b0, entLast = 1'b0;
  logic [31:0] entPrime = '0, entRoot = '0;
  logic outReady = 1'b1;
  logic candReady, entReady, outValid, outEnd;
  logic [31:0] outPrime;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] entP [8];
  logic [31:0] entS [8];
  int entN;
  logic [31:0] recPrime [16];
  int recCount;
  bit stallFirst = 0;

  always #5 clk = ~clk;

  trialdiv_top uut (
    .clk(clk), .rstN(rstN),
    .candValid(candValid), .candReady(candReady),
    .candA(candA), .candB(candB), .candAlg(candAlg),
    .entValid(entValid), .entReady(entReady),
    .entPrime(entPrime), .entRoot(entRoot), .entLast(entLast),
    .outValid(outValid), .outReady(outReady),
    .outPrime(outPrime), .outEnd(outEnd)
  );

  // Fields: a[128:97], b[96:65], s[64:33], p[32:1], alg[0]
  localparam logic [128:0] VEC [11] = '{
    {32'd10, 32'd3, 32'd5, 32'd5, 1'b0},                        // R2 divisible
    {-32'sd20, 32'd2, 32'd3, 32'd7, 1'b0},                      // R3 negative, divisible
    {-32'sd20, 32'd2, 32'd3, 32'd5, 1'b0},                      // R3 negative, not divisible
    {32'd7, 32'd1, 32'd0, 32'd7, 1'b1},                         // R2 algebraic
    {32'd139, 32'hFFFFFFFF, 32'd1073741788, 32'd1073741789, 1'b0}, // R4 full width, divisible
    {32'd140, 32'hFFFFFFFF, 32'd1073741788, 32'd1073741789, 1'b0}, // R4 full width, not divisible
    {32'd0, 32'd1, 32'd0, 32'd1073741824, 1'b0},                // R5 rational bound inclusive
    {32'd0, 32'd1, 32'd0, 32'd1073741824, 1'b1},                // R5 above algebraic bound
    {32'd134217728, 32'd0, 32'd0, 32'd134217728, 1'b1},         // R5 algebraic bound inclusive
    {32'd0, 32'd0, 32'd0, 32'd134217757, 1'b1},                 // R5 skipped
    {32'h80000000, 32'd0, 32'd0, 32'd2, 1'b0}                   // R3 most negative a
  };

  function automatic bit expDiv(logic signed [31:0] a, logic [31:0] b, logic [31:0] s,
                                logic [31:0] p, logic alg);
    logic signed [127:0] v, pv;
    logic [31:0] bnd;
    bnd = alg ? 32'd134217728 : 32'd1073741824;
    if (p > bnd) return 1'b0;
    v  = {{96{a[31]}}, a} + {64'd0, 64'(b) * 64'(s)};
    pv = {96'd0, p};
    return (v % pv) == 0;
  endfunction

  task automatic check(bit ok, string msg, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic drive(logic signed [31:0] a, logic [31:0] b, logic alg);
    @(negedge clk);
    candValid = 1'b1; candA = a; candB = b; candAlg = alg;
    while (!candReady) @(negedge clk);
    @(negedge clk);
    candValid = 1'b0;
    for (int i = 0; i < entN; i++) begin
      entValid = 1'b1; entPrime = entP[i]; entRoot = entS[i]; entLast = (i == entN - 1);
      while (!entReady) @(negedge clk);
      @(negedge clk);
      entValid = 1'b0;
    end
  endtask

  task automatic collect();
    logic [31:0] held;
    bit done = 0;
    recCount = 0;
    while (!done) begin
      @(negedge clk);
      if (outValid) begin
        if (stallFirst && recCount == 0 && !outEnd) begin
          outReady = 1'b0;
          held = outPrime;
          repeat (10) begin
            @(negedge clk);
            check(outValid && outPrime == held, "R7 stalled record held", outPrime, held);
            check(!candReady && !entReady, "R8 ready low while record waits",
                  {candReady, entReady}, 0);
          end
          outReady = 1'b1;
        end
        if (outEnd) begin
          check(outPrime == 0, "R6 end marker prime", outPrime, 0);
          done = 1;
        end else if (recCount < 16) begin
          recPrime[recCount] = outPrime;
          recCount++;
        end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!outValid, "R1 outValid after reset", outValid, 0);
    check(candReady, "R1 candReady after reset", candReady, 1);
    check(!entReady, "R1 entReady after reset", entReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(candReady && !outValid, "R1 idle after release", candReady, 1);

    // Table walk, one entry per candidate (R2 R3 R4 R5)
    for (int v = 0; v < 11; v++) begin
      bit e;
      entN = 1;
      entP[0] = VEC[v][32:1];
      entS[0] = VEC[v][64:33];
      e = expDiv(VEC[v][128:97], VEC[v][96:65], VEC[v][64:33], VEC[v][32:1], VEC[v][0]);
      fork
        drive(VEC[v][128:97], VEC[v][96:65], VEC[v][0]);
        collect();
      join
      check(recCount == (e ? 1 : 0), $sformatf("R2 R3 R4 R5 vector %0d record count", v),
            recCount, e ? 1 : 0);
      if (e && recCount == 1)
        check(recPrime[0] == VEC[v][32:1], $sformatf("R2 vector %0d prime", v),
              recPrime[0], VEC[v][32:1]);
    end

    // R6: several entries, records in entry order, with a stall (R7 R8)
    entN = 5;
    entP[0] = 2; entP[1] = 3; entP[2] = 4; entP[3] = 7; entP[4] = 5;
    for (int i = 0; i < 5; i++) entS[i] = 0;
    stallFirst = 1;
    fork
      drive(32'sd30, 32'd9, 1'b0);
      collect();
    join
    stallFirst = 0;
    check(recCount == 3, "R6 record count for five entries", recCount, 3);
    check(recPrime[0] == 2, "R6 first record", recPrime[0], 2);
    check(recPrime[1] == 3, "R6 second record", recPrime[1], 3);
    check(recPrime[2] == 5, "R6 third record", recPrime[2], 5);
    check(candReady, "R8 candReady back after end marker", candReady, 1);

    // R5: all entries skipped still yields exactly one end marker
    entN = 2;
    entP[0] = 32'd1073741827; entS[0] = 0;
    entP[1] = 32'd134217759;  entS[1] = 0;
    fork
      drive(32'sd0, 32'd1, 1'b1);
      collect();
    join
    check(recCount == 0, "R5 over-bound entries give no record", recCount, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule